// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Receiver Sleep

This block sends and receives asynchronous serial frames. A frame has one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. A 16-bit divider sets the rate of an oversampling tick, and each bit lasts 16 ticks. The receiver decides each bit by a majority vote over three samples taken at its centre. A received word is held on the outputs with a valid flag until the consumer acknowledges it.

The block works in one of two line modes. In full-duplex mode the transmitter always drives its own pin and the receiver listens to a separate pin. In single-wire mode both sides share one line. The transmitter enables its driver only while a frame is going out, and the receiver ignores the line during that time so it does not take in its own frame.

A sleep request puts the receiver to sleep, and while asleep it delivers no words. It wakes in one of two ways, chosen by an input. In idle-line mode it wakes once the line has been high for one full frame time. In address-mark mode it wakes on a frame whose top data bit is 1, and that frame is delivered.

Top module: `uart_wake_xcvr`

## Requirements
- R1: One bit lasts 16 ticks, and one tick lasts max(baud_div,1) clock cycles. A transmitted frame keeps tx_busy high for between T-d+1 and T cycles, where d = max(baud_div,1) and T = 16·d·(number of frame bits).
- R2: The transmitted frame is a low start bit, then data bits LSB first (tx_data[7:0] when nine_bit=0, tx_data[8:0] when nine_bit=1), then a high stop bit. A tx_start pulse while idle sets tx_busy on the next cycle. tx_pin is high whenever tx_busy is low.
- R3: A received frame appears on rx_data with the same bit layout. rx_data[8] is 0 in 8-bit mode.
- R4: rx_valid rises when a frame is delivered and stays high until an rx_ack pulse. A frame that arrives before the ack replaces rx_data.
- R5: If the stop bit is sampled low, rx_ferr is 1 for that word. It is 0 otherwise.
- R6: Each received bit takes the majority of samples 7, 8 and 9 of its 16 ticks. A glitch that lasts a single tick does not change the word.
- R7: A low pulse on an idle line that does not last until the centre of the start bit is dropped, and no word is produced.
- R8: When one_wire=1, tx_oe is high only while tx_busy is high, and the block's own transmitted frame produces no word.
- R9: When one_wire=0, tx_oe stays high, and a frame can be received while another is being transmitted.
- R10: sleep_req sets asleep. With wake_sel=0 (idle-line), no word is delivered while asleep. asleep clears once the line has been high with the receiver idle for (frame bits)·16 ticks counted from the sleep request, and the next frame is then delivered.
- R11: With wake_sel=1 (address-mark), frames whose top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is 0 are dropped while asleep. The first frame whose top bit is 1 clears asleep and is delivered.
- R12: After reset, tx_pin=1, tx_busy=0, rx_valid=0 and asleep=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 16 | Clock cycles per oversampling tick (0 is treated as 1) |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| one_wire | input | 1 | 1 selects the shared single-line mode |
| wake_sel | input | 1 | Wake method: 0 idle line, 1 address mark |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| tx_start | input | 1 | Pulse that starts sending tx_data |
| tx_data | input | 9 | Word to send |
| tx_busy | output | 1 | A frame is being sent |
| tx_pin | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit driver enable |
| rx_pin | input | 1 | Serial receive data (the shared line in single-wire mode) |
| rx_data | output | 9 | Last delivered word |
| rx_ferr | output | 1 | Framing error of the delivered word |
| rx_valid | output | 1 | A delivered word is waiting |
| rx_ack | input | 1 | Pulse that consumes the waiting word |
| asleep | output | 1 | The receiver is asleep |

## Verification
The bench uses the default parameters of 16 ticks per bit and at most 9 data bits. At run time it sets baud_div to 1 for the sweeps and to 2 or 3 elsewhere. With baud_div at 1 and the transmitter looped back to the receiver, every 8-bit value and a strided set of 9-bit values can be checked in a short run. With baud_div above 1, a pulse of exactly one tick can be placed inside a bit or on an idle line, which exercises the majority vote and the false-start rejection. The same settings make the frame-time idle threshold and the ±1-tick uncertainty in frame length measurable in clock cycles.

// File: rtl/uart_wake_pkg.sv
// Shared constants and types for the serial transceiver.
// Assumes a fixed 16x oversampling and at most 9 data bits.
package uart_wake_pkg;
    localparam int OSR      = 16;
    localparam int DATA_MAX = 9;
    localparam int FRAME_W  = DATA_MAX + 2;
    localparam int CNT_W    = $clog2(OSR);
    localparam int BIT_W    = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;
endpackage

// File: rtl/uwx_baud.sv
// Oversampling tick generator: produces one tick every max(div,1) cycles.
// Assumes div may change at any time; the counter then wraps at the new limit.
module uwx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // limit of the cycle counter, treating zero as one
    always_comb lim = (div == '0) ? '0 : div - 1'b1;

    assign tick = (cnt >= lim);

    // free-running cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uwx_tx.sv
// Transmit shifter: sends start, 8 or 9 data bits LSB first, and a stop bit,
// each lasting OSR ticks. Assumes start is ignored while busy.
module uwx_tx
    import uart_wake_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                nine_bit,
    input  logic                start,
    input  logic [DATA_MAX-1:0] data,
    output logic                busy,
    output logic                txd
);
    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   tcnt;
    logic [BIT_W-1:0]   bidx;
    logic [BIT_W-1:0]   last;

    // assemble the frame: start low, data, then stop and filler high
    always_comb begin
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (nine_bit || i < DATA_MAX - 1) frame[i+1] = data[i];
        end
    end

    // shift the frame out one bit every OSR ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            busy <= 1'b0;
            tcnt <= '0;
            bidx <= '0;
            last <= '0;
        end else if (start && !busy) begin
            sh   <= frame;
            busy <= 1'b1;
            tcnt <= '0;
            bidx <= '0;
            last <= nine_bit ? BIT_W'(FRAME_W - 1) : BIT_W'(FRAME_W - 2);
        end else if (busy && tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == CNT_W'(OSR - 1)) begin
                sh   <= {1'b1, sh[FRAME_W-1:1]};
                bidx <= bidx + 1'b1;
                if (bidx == last) busy <= 1'b0;
            end
        end
    end

    assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/uwx_rx.sv
// Receive sampler: finds a start edge, votes samples 7/8/9 of each bit,
// and reports the word at the stop-bit centre. Assumes rxd is synchronised.
module uwx_rx
    import uart_wake_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                nine_bit,
    input  logic                rxd,
    output logic                done,
    output logic                ferr,
    output logic [DATA_MAX-1:0] data,
    output logic                msb,
    output logic                quiet
);
    localparam int MID = OSR / 2;

    rx_state_e        st;
    logic [CNT_W-1:0] tcnt;
    logic [CNT_W-1:0] cnt_n;
    logic [BIT_W-1:0] bidx;
    logic             s_a, s_b, vote;

    assign cnt_n = tcnt + 1'b1;
    assign vote  = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
    assign msb   = nine_bit ? data[DATA_MAX-1] : data[DATA_MAX-2];
    assign quiet = (st == RX_IDLE) && rxd;

    // frame sampling state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            tcnt <= '0;
            bidx <= '0;
            s_a  <= 1'b1;
            s_b  <= 1'b1;
            data <= '0;
            done <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (st == RX_IDLE) begin
                    if (!rxd) begin
                        st   <= RX_START;
                        tcnt <= '0;
                        bidx <= '0;
                        data <= '0;
                    end
                end else begin
                    tcnt <= cnt_n;
                    if (cnt_n == CNT_W'(MID - 1)) s_a <= rxd;
                    if (cnt_n == CNT_W'(MID))     s_b <= rxd;
                    if (cnt_n == CNT_W'(MID + 1)) begin
                        case (st)
                            RX_START: if (vote) st <= RX_IDLE;
                            RX_DATA:  data[bidx] <= vote;
                            RX_STOP: begin
                                done <= 1'b1;
                                ferr <= !vote;
                                st   <= RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt_n == CNT_W'(OSR - 1)) begin
                        if (st == RX_START) begin
                            st   <= RX_DATA;
                            bidx <= '0;
                        end else if (st == RX_DATA) begin
                            if (bidx == (nine_bit ? BIT_W'(DATA_MAX - 1) : BIT_W'(DATA_MAX - 2)))
                                st <= RX_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uwx_wake.sv
// Sleep and wake control: gates word delivery while asleep and wakes on a
// frame-long idle line or an address-marked frame, as wake_sel selects.
// Assumes the idle count restarts at each sleep request.
module uwx_wake
    import uart_wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic nine_bit,
    input  logic wake_sel,
    input  logic sleep_req,
    input  logic quiet,
    input  logic frame_done,
    input  logic frame_msb,
    output logic asleep,
    output logic deliver
);
    localparam int IDLE_MAX = FRAME_W * OSR;
    localparam int IDLE_W   = $clog2(IDLE_MAX + 1);

    logic [IDLE_W-1:0] icnt;
    logic [IDLE_W-1:0] thr;
    logic              idle_hit, addr_hit;

    assign thr      = nine_bit ? IDLE_W'(FRAME_W * OSR) : IDLE_W'((FRAME_W - 1) * OSR);
    assign idle_hit = (wake_mode_e'(wake_sel) == WAKE_IDLE) && (icnt >= thr);
    assign addr_hit = (wake_mode_e'(wake_sel) == WAKE_ADDR) && frame_done && frame_msb;
    assign deliver  = frame_done && (!asleep || addr_hit);

    // count idle ticks of a high line, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n || sleep_req || !quiet) icnt <= '0;
        else if (tick && icnt < thr)       icnt <= icnt + 1'b1;
    end

    // sleep flag: set by request, cleared by the selected wake event
    always_ff @(posedge clk) begin
        if (!rst_n)                               asleep <= 1'b0;
        else if (sleep_req)                       asleep <= 1'b1;
        else if (asleep && (idle_hit || addr_hit)) asleep <= 1'b0;
    end
endmodule

// File: rtl/uart_wake_xcvr.sv
// Top level: tick generator, transmitter, receiver and wake control, plus
// the input synchroniser, single-wire gating and the held output word.
// Assumes rx_pin is asynchronous and the mode inputs change only while idle.
module uart_wake_xcvr
    import uart_wake_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic                nine_bit,
    input  logic                one_wire,
    input  logic                wake_sel,
    input  logic                sleep_req,
    input  logic                tx_start,
    input  logic [DATA_MAX-1:0] tx_data,
    output logic                tx_busy,
    output logic                tx_pin,
    output logic                tx_oe,
    input  logic                rx_pin,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_ferr,
    output logic                rx_valid,
    input  logic                rx_ack,
    output logic                asleep
);
    logic                tick;
    logic [1:0]          sync;
    logic                rxd;
    logic                f_done, f_err, f_msb, quiet, deliver;
    logic [DATA_MAX-1:0] f_data;

    // two-stage synchroniser for the receive pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx_pin};
    end

    // in single-wire mode the receiver sees an idle line during its own frame
    assign rxd   = (one_wire && tx_busy) ? 1'b1 : sync[1];
    assign tx_oe = one_wire ? tx_busy : 1'b1;

    uwx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    uwx_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine_bit(nine_bit),
        .start(tx_start), .data(tx_data), .busy(tx_busy), .txd(tx_pin)
    );

    uwx_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine_bit(nine_bit),
        .rxd(rxd), .done(f_done), .ferr(f_err), .data(f_data),
        .msb(f_msb), .quiet(quiet)
    );

    uwx_wake u_wake (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine_bit(nine_bit),
        .wake_sel(wake_sel), .sleep_req(sleep_req), .quiet(quiet),
        .frame_done(f_done), .frame_msb(f_msb),
        .asleep(asleep), .deliver(deliver)
    );

    // hold the delivered word until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ferr  <= 1'b0;
            rx_valid <= 1'b0;
        end else if (deliver) begin
            rx_data  <= f_data;
            rx_ferr  <= f_err;
            rx_valid <= 1'b1;
        end else if (rx_ack) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_wake_chk.sv
// Property checker for the transceiver, attached to every instance by bind.
module uart_wake_chk (
    input logic clk,
    input logic rst_n,
    input logic one_wire,
    input logic wake_sel,
    input logic sleep_req,
    input logic tx_start,
    input logic tx_busy,
    input logic tx_pin,
    input logic tx_oe,
    input logic rx_valid,
    input logic rx_ack,
    input logic asleep
);
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_pin);

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && !tx_busy) |=> tx_busy);

    a_r4_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ack) |=> rx_valid);

    a_r8_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (one_wire && !tx_busy) |-> !tx_oe);

    a_r9_oe_full: assert property (@(posedge clk) disable iff (!rst_n)
        !one_wire |-> tx_oe);

    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !wake_sel) |=> !$rose(rx_valid));

    a_r11_mark_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake_sel && !sleep_req) |=> (!$rose(rx_valid) || !asleep));
endmodule

bind uart_wake_xcvr uart_wake_chk u_chk (
    .clk(clk), .rst_n(rst_n), .one_wire(one_wire), .wake_sel(wake_sel),
    .sleep_req(sleep_req), .tx_start(tx_start), .tx_busy(tx_busy),
    .tx_pin(tx_pin), .tx_oe(tx_oe), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .asleep(asleep)
);

// File: tb/tb_uart_wake_xcvr.sv
`timescale 1ns/1ps
module tb_uart_wake_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic       nine_bit = 1'b0, one_wire = 1'b0, wake_sel = 1'b0;
    logic       sleep_req = 1'b0, tx_start = 1'b0, rx_ack = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_busy, tx_pin, tx_oe, rx_ferr, rx_valid, asleep, rx_pin;
    logic [8:0] rx_data;
    logic       bline = 1'b1;
    logic [1:0] lmode = 2'd0;   // 0 bench line, 1 loopback, 2 shared wire
    int         checks = 0, fails = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    assign rx_pin = (lmode == 2'd1) ? tx_pin :
                    (lmode == 2'd2) ? (tx_oe ? tx_pin : bline) : bline;

    uart_wake_xcvr dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .nine_bit(nine_bit),
        .one_wire(one_wire), .wake_sel(wake_sel), .sleep_req(sleep_req),
        .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy),
        .tx_pin(tx_pin), .tx_oe(tx_oe), .rx_pin(rx_pin), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_valid(rx_valid), .rx_ack(rx_ack), .asleep(asleep)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dv();
        return (baud_div == 0) ? 1 : int'(baud_div);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack();
        rx_ack = 1'b1; cyc(1); rx_ack = 1'b0; cyc(1);
    endtask

    // drive one frame on bench line; glitch_bit>=0 inverts one tick at its centre
    task automatic send(input logic [8:0] v, input bit stop, input int glitch_bit);
        int nb = nine_bit ? 9 : 8;
        logic [10:0] fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < nb; i++) fr[i+1] = v[i];
        fr[nb+1] = stop;
        for (int b = 0; b < nb + 2; b++) begin
            bline = fr[b];
            if (b == glitch_bit) begin
                cyc(8 * dv());
                bline = ~fr[b];
                cyc(dv());
                bline = fr[b];
                cyc(7 * dv());
            end else cyc(16 * dv());
        end
        bline = 1'b1;
    endtask

    task automatic wait_valid(output bit got);
        got = 0;
        for (int i = 0; i < 400 * dv(); i++) begin
            if (rx_valid) begin got = 1; break; end
            cyc(1);
        end
    endtask

    task automatic xmit(input logic [8:0] v);
        tx_data = v; tx_start = 1'b1; cyc(1); tx_start = 1'b0;
    endtask

    initial begin
        bit got;
        int cnt, d, nb;
        logic [8:0] exp;
        cyc(3);
        // R12 reset state
        chk(tx_pin == 1'b1, "R12 tx_pin", tx_pin, 1);
        chk(tx_busy == 1'b0, "R12 tx_busy", tx_busy, 0);
        chk(rx_valid == 1'b0, "R12 rx_valid", rx_valid, 0);
        chk(asleep == 1'b0, "R12 asleep", asleep, 0);
        rst_n = 1'b1; cyc(2);

        // R3 sweep of all 8-bit values through loopback
        lmode = 2'd1; baud_div = 16'd1;
        for (int v = 0; v < 256; v++) begin
            xmit(9'(v)); wait_valid(got);
            chk(got && rx_data == 9'(v), "R3 8-bit loopback", rx_data, v);
            chk(rx_ferr == 1'b0, "R5 no ferr", rx_ferr, 0);
            ack();
            chk(rx_valid == 1'b0, "R4 cleared by ack", rx_valid, 0);
            cyc(20);
        end
        // R3 strided 9-bit sweep
        nine_bit = 1'b1;
        for (int v = 0; v < 512; v += 7) begin
            xmit(9'(v)); wait_valid(got);
            chk(got && rx_data == 9'(v), "R3 9-bit loopback", rx_data, v);
            ack(); cyc(20);
        end

        // R2 transmit waveform and R1 frame length
        lmode = 2'd0;
        for (int k = 0; k < 4; k++) begin
            nine_bit = k[0];
            baud_div = (k < 2) ? 16'd2 : 16'd3;
            d = dv(); nb = nine_bit ? 9 : 8;
            exp = (k == 0) ? 9'h0B5 : (k == 1) ? 9'h14E : (k == 2) ? 9'h061 : 9'h1F0;
            xmit(exp);
            while (tx_pin) cyc(1);
            cyc(8 * d);
            chk(tx_pin == 1'b0, "R2 start bit", tx_pin, 0);
            for (int b = 0; b < nb; b++) begin
                cyc(16 * d);
                chk(tx_pin == exp[b], "R2 data bit", tx_pin, exp[b]);
            end
            cyc(16 * d);
            chk(tx_pin == 1'b1, "R2 stop bit", tx_pin, 1);
            while (tx_busy) cyc(1);
            cyc(4);
            xmit(exp); cnt = 1;
            while (tx_busy) begin cnt++; cyc(1); end
            chk(cnt >= 16 * d * (nb + 2) - d + 1 && cnt <= 16 * d * (nb + 2),
                "R1 frame length", cnt, 16 * d * (nb + 2));
            cyc(10);
        end

        // R4 overwrite before ack
        nine_bit = 1'b0; baud_div = 16'd2;
        send(9'h3A, 1, -1); send(9'h5C, 1, -1); cyc(4);
        chk(rx_valid == 1'b1, "R4 held without ack", rx_valid, 1);
        chk(rx_data == 9'h05C, "R4 newest word", rx_data, 9'h05C);
        ack();

        // R5 framing error
        send(9'hC3, 0, -1); cyc(4);
        chk(rx_valid && rx_ferr == 1'b1, "R5 ferr set", rx_ferr, 1);
        chk(rx_data == 9'h0C3, "R5 data with ferr", rx_data, 9'h0C3);
        ack(); cyc(40);

        // R6 single-tick glitches inside data bits
        send(9'h000, 1, 4); cyc(4);
        chk(rx_valid && rx_data == 9'h000, "R6 glitch high", rx_data, 0);
        ack();
        send(9'h0FF, 1, 2); cyc(4);
        chk(rx_valid && rx_data == 9'h0FF, "R6 glitch low", rx_data, 9'h0FF);
        ack();

        // R7 false start
        cyc(50); bline = 1'b0; cyc(dv()); bline = 1'b1; cyc(400);
        chk(rx_valid == 1'b0, "R7 false start dropped", rx_valid, 0);
        send(9'h0A7, 1, -1); cyc(4);
        chk(rx_valid && rx_data == 9'h0A7, "R7 frame after glitch", rx_data, 9'h0A7);
        ack();

        // R9 full duplex: receive during transmit
        xmit(9'h0A5);
        send(9'h03C, 1, -1); cyc(4);
        chk(tx_oe == 1'b1, "R9 oe held", tx_oe, 1);
        chk(rx_valid && rx_data == 9'h03C, "R9 concurrent rx", rx_data, 9'h03C);
        ack(); while (tx_busy) cyc(1);

        // R8 single wire
        one_wire = 1'b1; lmode = 2'd2; cyc(2);
        chk(tx_oe == 1'b0, "R8 oe off idle", tx_oe, 0);
        xmit(9'h055); cyc(2);
        chk(tx_oe == 1'b1, "R8 oe on busy", tx_oe, 1);
        while (tx_busy) cyc(1);
        cyc(4);
        chk(tx_oe == 1'b0, "R8 oe released", tx_oe, 0);
        chk(rx_valid == 1'b0, "R8 own frame ignored", rx_valid, 0);
        send(9'h096, 1, -1); cyc(4);
        chk(rx_valid && rx_data == 9'h096, "R8 shared rx", rx_data, 9'h096);
        ack();
        one_wire = 1'b0; lmode = 2'd0; cyc(40);

        // R10 idle-line wake
        wake_sel = 1'b0;
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
        chk(asleep == 1'b1, "R10 asleep set", asleep, 1);
        send(9'h011, 1, -1); send(9'h0E2, 1, -1); cyc(4);
        chk(rx_valid == 1'b0, "R10 suppressed", rx_valid, 0);
        chk(asleep == 1'b1, "R10 still asleep", asleep, 1);
        cyc((160 + 40) * dv());
        chk(asleep == 1'b0, "R10 woke on idle", asleep, 0);
        send(9'h04D, 1, -1); cyc(4);
        chk(rx_valid && rx_data == 9'h04D, "R10 frame after wake", rx_data, 9'h04D);
        ack(); cyc(20);

        // R11 address-mark wake, 8-bit then 9-bit
        wake_sel = 1'b1;
        for (int m = 0; m < 2; m++) begin
            nine_bit = m[0];
            sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
            send(m ? 9'h0FF : 9'h012, 1, -1); cyc(4);
            chk(rx_valid == 1'b0, "R11 unmarked dropped", rx_valid, 0);
            chk(asleep == 1'b1, "R11 still asleep", asleep, 1);
            exp = m ? 9'h105 : 9'h083;
            send(exp, 1, -1); cyc(4);
            chk(rx_valid && rx_data == exp, "R11 marked delivered", rx_data, exp);
            chk(asleep == 1'b0, "R11 woke", asleep, 0);
            ack(); cyc(20);
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule